// File: doc/BRIEF.md
# General-Purpose I/O Port with Pull-Up Control

This block is one memory-mapped I/O port for a small microcontroller bus. Software sees three byte-wide locations: a data latch, a direction register and a read-only pin-sampling location. From the two stored registers the block makes three signals for each pad: an output enable, an output level and a pull-up enable. The pad cells themselves are outside this block.

Pins 4 down to 0 are ordinary bidirectional lines. When a pin's direction bit is set, the pin drives its latch bit push-pull. When the direction bit is clear, the latch bit chooses the weak pull-up instead, unless the global pull-up-disable input is high. Pin 5 has no high-side driver. Depending on a variant parameter, it is either an open-drain line that can only pull low or a pure input. The pad levels pass through a two-flop synchronizer before software can read them.

The bus is a plain single-cycle strobe interface with no valid/ready handshake and no back-pressure. Every write is accepted on the clock edge where the strobe is high. Read data is combinational from the address and is valid in the same cycle.

Top module: `gpio_pullup_port`

## Requirements
- R1: Address 0x18 reads the data latch, 0x17 reads the direction register and 0x16 reads the synchronized pad levels. Every other address reads 0x00.
- R2: The data latch stores bits 4..0 of a write. Bits 7..5 always read 0, and the latch resets to 0x00.
- R3: The direction register stores bits 5..0 of a write. Bit 5 is stored only when OD_EN=1 and otherwise reads 0. Bits 7..6 always read 0, and the register resets to 0x00.
- R4: Address 0x16 returns bit i = level of pad_in[i] for i = 5..0, with bits 7..6 at 0. A pad change made before clock edge k is visible after edge k+1 and not before (two registers).
- R5: For pins 4..0, pad_oe[i] equals direction bit i and pad_out[i] equals latch bit i.
- R6: For pins 4..0, pad_pu[i] is 1 exactly when direction bit i is 0, latch bit i is 1 and pullup_off is 0.
- R7: Pin 5 never drives high and never enables its pull-up. pad_out[5] and pad_pu[5] are always 0, and pad_oe[5] equals direction bit 5.
- R8: While rst_n is low, all pad_oe and pad_pu bits are 0 at once, with no clock edge needed. The registers and the synchronizer clear asynchronously.
- R9: A register changes only on a clock edge where bus_wr is 1 and bus_addr is that register's address. Writes to 0x16 or to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | I/O address |
| bus_wr | input | 1 | Write strobe, acted on at the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| pad_in | input | 6 | Raw pad levels, asynchronous to clk |
| pullup_off | input | 1 | Global pull-up disable |
| pad_oe | output | 6 | Per-pad output enable |
| pad_out | output | 6 | Per-pad output level |
| pad_pu | output | 6 | Per-pad pull-up enable |

## Verification
The clocked properties assume that bus_addr, bus_wr and bus_wdata are stable around each rising edge. They also assume that pullup_off is a level that changes only between edges. The bench meets this by driving every input one time unit after a falling edge. The only input it drives off that grid is rst_n, to check the asynchronous clear. The pads are treated as asynchronous, and the properties make no claim about pad_in. The bench changes pad_in only on the same falling-edge grid, so its reference pipeline and the synchronizer see the same values.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam int NUM_PP = 5;
  localparam logic [ADDR_W-1:0] A_PINS  = 6'h16;
  localparam logic [ADDR_W-1:0] A_DIR   = 6'h17;
  localparam logic [ADDR_W-1:0] A_LATCH = 6'h18;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int NUM_PP = 5,
  parameter int OD_EN  = 1,
  localparam int NUM_PINS = NUM_PP + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [NUM_PINS-1:0] pin_val,
  output logic [DATA_W-1:0]   rdata,
  output logic [DATA_W-1:0]   latch_q,
  output logic [DATA_W-1:0]   dir_q
);
  localparam logic [DATA_W-1:0] LATCH_MASK = DATA_W'((1 << NUM_PP) - 1);
  localparam logic [DATA_W-1:0] DIR_MASK   = DATA_W'((1 << (NUM_PP + OD_EN)) - 1);

  logic wr_latch, wr_dir;
  assign wr_latch = wr && (addr == A_LATCH);
  assign wr_dir   = wr && (addr == A_DIR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latch_q <= '0;
    else if (wr_latch) latch_q <= wdata & LATCH_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (wr_dir) dir_q <= wdata & DIR_MASK;
  end

  always_comb begin
    unique case (addr)
      A_LATCH: rdata = latch_q;
      A_DIR:   rdata = dir_q;
      A_PINS:  rdata = {{(DATA_W-NUM_PINS){1'b0}}, pin_val};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
  parameter int NUM_PP = 5,
  localparam int NUM_PINS = NUM_PP + 1
) (
  input  logic                rst_n,
  input  logic                pu_dis,
  input  logic [NUM_PP-1:0]   latch,
  input  logic [NUM_PINS-1:0] dir,
  output logic [NUM_PINS-1:0] oe,
  output logic [NUM_PINS-1:0] out,
  output logic [NUM_PINS-1:0] pu
);
  for (genvar i = 0; i < NUM_PP; i++) begin : g_pp
    assign oe[i]  = rst_n & dir[i];
    assign out[i] = latch[i];
    assign pu[i]  = rst_n & ~dir[i] & latch[i] & ~pu_dis;
  end

  // open-drain pin: only ever pulls low, no pull-up
  assign oe[NUM_PP]  = rst_n & dir[NUM_PP];
  assign out[NUM_PP] = 1'b0;
  assign pu[NUM_PP]  = 1'b0;
endmodule

// File: rtl/gpio_pullup_port.sv
module gpio_pullup_port
  import gpio_port_pkg::*;
#(
  parameter int OD_EN       = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_PP:0]   pad_in,
  input  logic              pullup_off,
  output logic [NUM_PP:0]   pad_oe,
  output logic [NUM_PP:0]   pad_out,
  output logic [NUM_PP:0]   pad_pu
);
  localparam int NUM_PINS = NUM_PP + 1;

  logic [NUM_PINS-1:0] pin_sync;
  logic [DATA_W-1:0]   latch_q, dir_q;

  gpio_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
  );

  gpio_regs #(.NUM_PP(NUM_PP), .OD_EN(OD_EN)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr),
    .wdata(bus_wdata), .pin_val(pin_sync), .rdata(bus_rdata),
    .latch_q(latch_q), .dir_q(dir_q)
  );

  gpio_pad_drive #(.NUM_PP(NUM_PP)) u_drive (
    .rst_n(rst_n), .pu_dis(pullup_off),
    .latch(latch_q[NUM_PP-1:0]), .dir(dir_q[NUM_PINS-1:0]),
    .oe(pad_oe), .out(pad_out), .pu(pad_pu)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int OD_EN = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              pullup_off,
  input logic [NUM_PP:0]   pad_oe,
  input logic [NUM_PP:0]   pad_out,
  input logic [NUM_PP:0]   pad_pu
);
  logic mapped;
  assign mapped = (bus_addr == A_LATCH) || (bus_addr == A_DIR) || (bus_addr == A_PINS);

  // R8: reset silences every driver and pull-up without a clock
  always_comb begin
    if (!rst_n) a_r8_reset_idle: assert ((pad_oe == '0) && (pad_pu == '0));
  end

  a_r6_no_pu_on_output: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0);

  a_r6_global_disable: assert property (@(posedge clk) disable iff (!rst_n)
    pullup_off |-> (pad_pu == '0));

  a_r1_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (bus_rdata == '0));

  a_r4_pin_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_PINS) |-> (bus_rdata[DATA_W-1:NUM_PP+1] == '0));

  a_r2_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_LATCH) |=> (pad_out[NUM_PP-1:0] == $past(bus_wdata[NUM_PP-1:0])));

  a_r7_od_follows_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DIR) |=> (pad_oe[NUM_PP] == ((OD_EN != 0) && $past(bus_wdata[NUM_PP]))));

  a_r9_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == A_LATCH) |=> $stable(pad_out));

  a_r9_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == A_DIR) |=> $stable(pad_oe));
endmodule

bind gpio_pullup_port gpio_port_chk #(.OD_EN(OD_EN)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pullup_off(pullup_off),
  .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
);

// File: tb/gpio_pullup_port_tb.sv
module gpio_pullup_port_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [5:0] bus_addr = 0;
  logic       bus_wr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic [5:0] pad_in = 0;
  logic       pullup_off = 0;
  logic [5:0] pad_oe, pad_out, pad_pu;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_pullup_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pullup_off(pullup_off), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  // behavioural reference: register contents and a two-deep pad queue
  int   m_latch, m_dir;
  int   pq[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_latch = 0; m_dir = 0; pq = '{0, 0};
    end else begin
      if (bus_wr && bus_addr == 6'h18) m_latch = bus_wdata & 8'h1F;
      if (bus_wr && bus_addr == 6'h17) m_dir = bus_wdata & 8'h3F;
      pq.push_back(int'(pad_in));
      void'(pq.pop_front());
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_rd();
    case (bus_addr)
      6'h18: return m_latch;
      6'h17: return m_dir;
      6'h16: return pq[0];
      default: return 0;
    endcase
  endfunction

  function automatic int exp_oe();
    return rst_n ? m_dir : 0;
  endfunction

  function automatic int exp_pu();
    int r = 0;
    for (int i = 0; i < 5; i++)
      if (rst_n && !m_dir[i] && m_latch[i] && !pullup_off) r |= (1 << i);
    return r;
  endfunction

  function automatic string rd_tag();
    case (bus_addr)
      6'h18: return "R2";
      6'h17: return "R3";
      6'h16: return "R4";
      default: return "R1";
    endcase
  endfunction

  // compare on every falling edge
  always @(negedge clk) begin
    if (!done) begin
      chk(rd_tag(), bus_rdata, exp_rd());
      chk("R5 oe", pad_oe[4:0], exp_oe() & 5'h1F);
      chk("R5 out", pad_out[4:0], m_latch & 5'h1F);
      chk("R6 pu", pad_pu, exp_pu());
      chk("R7 pin5", {pad_out[5], pad_pu[5], pad_oe[5]}, rst_n ? m_dir[5] : 0);
    end
  end

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); #1 bus_addr = a; bus_wr = 1; bus_wdata = d;
    @(negedge clk); #1 bus_wr = 0;
  endtask

  task automatic rd_chk(string tag, input logic [5:0] a, int exp);
    @(negedge clk); #1 bus_addr = a; #1 chk(tag, bus_rdata, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1 chk("R8 reset oe", pad_oe, 0);
    chk("R8 reset pu", pad_pu, 0);
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    rd_chk("R2 reset latch", 6'h18, 8'h00);
    rd_chk("R3 reset dir", 6'h17, 8'h00);

    wr(6'h18, 8'hFF);
    rd_chk("R2 upper bits zero", 6'h18, 8'h1F);
    #1 chk("R6 pull-ups on inputs", pad_pu, 6'h1F);
    @(negedge clk); #1 pullup_off = 1; #1 chk("R6 global off", pad_pu, 0);
    @(negedge clk); #1 pullup_off = 0;

    wr(6'h17, 8'hFF);
    rd_chk("R3 dir bits 5..0", 6'h17, 8'h3F);
    #1 chk("R6 no pull-up on output", pad_pu, 0);
    chk("R7 pin5 low only", {pad_out[5], pad_oe[5]}, 2'b01);

    // R9: write to pin address and a non-strobed write are ignored
    wr(6'h16, 8'h00);
    @(negedge clk); #1 bus_addr = 6'h18; bus_wdata = 8'h00; bus_wr = 0;
    rd_chk("R9 latch kept", 6'h18, 8'h1F);
    rd_chk("R9 dir kept", 6'h17, 8'h3F);
    wr(6'h3F, 8'h00);
    rd_chk("R9 unmapped write ignored", 6'h18, 8'h1F);
    rd_chk("R1 unmapped reads zero", 6'h00, 8'h00);

    // R4 latency: pad changes seen after the second edge
    @(negedge clk); #1 bus_addr = 6'h16; pad_in = 6'h2A; #1 chk("R4 before edge", bus_rdata, 8'h00);
    @(negedge clk); #1 chk("R4 one edge", bus_rdata, 8'h00);
    @(negedge clk); #1 chk("R4 two edges", bus_rdata, 8'h2A);
    @(negedge clk); #1 pad_in = 6'h15;
    @(negedge clk); @(negedge clk); #1 chk("R4 second pattern", bus_rdata, 8'h15);

    // random traffic compared each cycle by the model
    for (int n = 0; n < 400; n++) begin
      @(negedge clk); #1;
      case ($urandom_range(0, 3))
        0: bus_addr = 6'h16;
        1: bus_addr = 6'h17;
        2: bus_addr = 6'h18;
        default: bus_addr = 6'($urandom);
      endcase
      bus_wr = $urandom_range(0, 1) == 1;
      bus_wdata = 8'($urandom);
      pad_in = 6'($urandom);
      pullup_off = $urandom_range(0, 3) == 0;
    end
    @(negedge clk); #1 bus_wr = 0; pullup_off = 0;

    // R8: asynchronous reset in the middle of a clock phase
    wr(6'h18, 8'h0F);
    wr(6'h17, 8'h30);
    @(posedge clk); #2 rst_n = 0; #1;
    chk("R8 async oe", pad_oe, 0);
    chk("R8 async pu", pad_pu, 0);
    @(negedge clk); @(negedge clk); #1 rst_n = 1;
    rd_chk("R8 latch cleared", 6'h18, 8'h00);

    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule